// File: doc/BRIEF.md
# 64-bit Integer Execute Stage

This block is the integer execute stage of a 64-bit processor pipeline. Each clock it takes an already decoded operation code, two 64-bit register operands and a 5-bit immediate shift amount. One cycle later it presents the result, a destination write-enable and two exception flags. The supported operations are:

- signed and unsigned set-on-less-than;
- add and subtract, each with or without a check for signed overflow;
- left, logical-right and arithmetic-right shifts by the immediate amount, each also in a form that adds 32 to the amount.

A mode input says whether 64-bit (doubleword) instructions are allowed. With the mode off, every doubleword add, subtract and shift is refused with a reserved-instruction exception. The comparisons still run with the mode off. The pipeline around the block sees an exception flag and a suppressed write, and it takes the exception. Register storage, fetch, instruction-field decoding and exception vectoring belong to neighbouring blocks.

Top module: `exu_top`

## Requirements
- R1: While `rstN` is low, `result`, `wrEn`, `ovfExc` and `rsvdExc` are all 0.
- R2: Operation code 0 (signed less-than) writes 1 when `opA` < `opB` as two's-complement values, and 0 otherwise.
- R3: Operation code 1 (unsigned less-than) writes 1 when `opA` < `opB` as unsigned values, and 0 otherwise.
- R4: Operation code 2 (checked add) sets `ovfExc` when both operands have the same sign bit and the sum's sign bit differs from it. Otherwise it writes the sum.
- R5: Operation code 4 (checked subtract, `opA` − `opB`) sets `ovfExc` when `opB` is negative and the difference is below `opA`, or when `opB` is positive and the difference is above `opA`, both compared as signed values. Otherwise it writes the difference.
- R6: Operation codes 3 (add) and 5 (subtract) never set `ovfExc` and always write the result wrapped to 64 bits.
- R7: With `wideEn` = 0, operation codes 2 to 11 set `rsvdExc` and do not write. Codes 0 and 1 are not affected by `wideEn`.
- R8: Operation code 6 shifts `opB` left by `shAmt`. Bits shifted out above bit 63 are lost and the low bits fill with zeros.
- R9: Operation code 7 shifts `opB` right by `shAmt` and fills the upper bits with zeros.
- R10: Operation code 8 shifts `opB` right by `shAmt` and copies bit 63 into the vacated upper bits.
- R11: Operation codes 9, 10 and 11 act as codes 6, 7 and 8 respectively, with a shift amount of `shAmt` + 32 (32 to 63).
- R12: Operation codes 12 to 15 set `rsvdExc` and do not write.
- R13: Outputs appear one clock after the inputs are sampled. Whenever `ovfExc` or `rsvdExc` is 1, `wrEn` is 0 and `result` is 0. The two exception flags are never both 1; the reserved-instruction exception takes priority over overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stage clock |
| rstN | input | 1 | Active-low synchronous reset |
| opSel | input | 4 | Decoded operation code |
| opA | input | 64 | First register operand |
| opB | input | 64 | Second register operand (shift source) |
| shAmt | input | 5 | Immediate shift amount |
| wideEn | input | 1 | 1 allows doubleword operations |
| result | output | 64 | Registered result, 0 when no write |
| wrEn | output | 1 | Destination write-enable |
| ovfExc | output | 1 | Integer-overflow exception |
| rsvdExc | output | 1 | Reserved-instruction exception |

## Verification
The bench builds the block with its default parameters: a 64-bit datapath and a 5-bit shift field. With these values, the sign-boundary operands (most negative, most positive, −1, 0) reach both overflow rules and both comparison orders. The +32 shift forms reach the effective amounts 32 to 63, including 63. A pseudo-random stream of operands, codes and mode values then mixes the mode gate, the unused codes and every operation against an independent reference model.

// File: rtl/exu_pkg.sv
package exu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_SLT    = 4'd0,
    OP_SLTU   = 4'd1,
    OP_ADDT   = 4'd2,
    OP_ADDW   = 4'd3,
    OP_SUBT   = 4'd4,
    OP_SUBW   = 4'd5,
    OP_SHL    = 4'd6,
    OP_SHRL   = 4'd7,
    OP_SHRA   = 4'd8,
    OP_SHL32  = 4'd9,
    OP_SHRL32 = 4'd10,
    OP_SHRA32 = 4'd11
  } exuOp_e;

  // strobes from control to datapath / writeback
  typedef struct packed {
    logic legal;
    logic needWide;
    logic selSlt;
    logic cmpUnsigned;
    logic selAdd;
    logic selSub;
    logic selShift;
    logic shLeft;
    logic shArith;
    logic plus32;
    logic trapOvf;
  } exuStrobe_t;
endpackage

// File: rtl/exu_ctrl.sv
module exu_ctrl
  import exu_pkg::*;
(
  input  logic [OP_W-1:0] opSel,
  output exuStrobe_t      strb
);
  always_comb begin
    strb = '0;
    strb.legal = 1'b1;
    case (opSel)
      OP_SLT:  strb.selSlt = 1'b1;
      OP_SLTU: begin strb.selSlt = 1'b1; strb.cmpUnsigned = 1'b1; end
      OP_ADDT: begin strb.selAdd = 1'b1; strb.trapOvf = 1'b1; strb.needWide = 1'b1; end
      OP_ADDW: begin strb.selAdd = 1'b1; strb.needWide = 1'b1; end
      OP_SUBT: begin strb.selSub = 1'b1; strb.trapOvf = 1'b1; strb.needWide = 1'b1; end
      OP_SUBW: begin strb.selSub = 1'b1; strb.needWide = 1'b1; end
      OP_SHL:  begin strb.selShift = 1'b1; strb.shLeft = 1'b1; strb.needWide = 1'b1; end
      OP_SHRL: begin strb.selShift = 1'b1; strb.needWide = 1'b1; end
      OP_SHRA: begin strb.selShift = 1'b1; strb.shArith = 1'b1; strb.needWide = 1'b1; end
      OP_SHL32: begin
        strb.selShift = 1'b1; strb.shLeft = 1'b1; strb.plus32 = 1'b1; strb.needWide = 1'b1;
      end
      OP_SHRL32: begin
        strb.selShift = 1'b1; strb.plus32 = 1'b1; strb.needWide = 1'b1;
      end
      OP_SHRA32: begin
        strb.selShift = 1'b1; strb.shArith = 1'b1; strb.plus32 = 1'b1; strb.needWide = 1'b1;
      end
      default: strb.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/exu_datapath.sv
module exu_datapath
  import exu_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int SHAMT_W = 5
) (
  input  exuStrobe_t        strb,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [SHAMT_W-1:0] shAmt,
  output logic [DATA_W-1:0] rawResult,
  output logic              sumOvf
);
  localparam int AMT_W  = $clog2(DATA_W);
  localparam int STAGES = AMT_W;
  localparam int HALF   = DATA_W / 2;

  // add / subtract
  logic [DATA_W-1:0] sumVal;
  logic [DATA_W-1:0] diffVal;
  logic addOvf;
  logic subOvf;

  assign sumVal  = opA + opB;
  assign diffVal = opA - opB;

  assign addOvf = (opA[DATA_W-1] == opB[DATA_W-1]) && (sumVal[DATA_W-1] != opA[DATA_W-1]);

  always_comb begin
    subOvf = 1'b0;
    if ($signed(opB) < 0 && $signed(diffVal) < $signed(opA)) subOvf = 1'b1;
    if ($signed(opB) > 0 && $signed(diffVal) > $signed(opA)) subOvf = 1'b1;
  end

  assign sumOvf = strb.selAdd ? addOvf : (strb.selSub ? subOvf : 1'b0);

  // comparison
  logic lessThan;
  assign lessThan = strb.cmpUnsigned ? (opA < opB) : ($signed(opA) < $signed(opB));

  // barrel shifter: right shifter, left shift by reversal
  logic [AMT_W-1:0] effAmt;
  assign effAmt = AMT_W'(shAmt) + (strb.plus32 ? AMT_W'(HALF) : AMT_W'(0));

  function automatic logic [DATA_W-1:0] bitRev(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    for (int k = 0; k < DATA_W; k++) r[k] = v[DATA_W-1-k];
    return r;
  endfunction

  logic fillBit;
  logic [DATA_W-1:0] stage [0:STAGES];
  assign fillBit  = strb.shArith & opB[DATA_W-1];
  assign stage[0] = strb.shLeft ? bitRev(opB) : opB;

  for (genvar i = 0; i < STAGES; i++) begin : g_shStage
    localparam int SH = 1 << i;
    assign stage[i+1] = effAmt[i] ? {{SH{fillBit}}, stage[i][DATA_W-1:SH]} : stage[i];
  end

  logic [DATA_W-1:0] shiftVal;
  assign shiftVal = strb.shLeft ? bitRev(stage[STAGES]) : stage[STAGES];

  // result select
  always_comb begin
    rawResult = '0;
    if (strb.selSlt)        rawResult = {{(DATA_W-1){1'b0}}, lessThan};
    else if (strb.selAdd)   rawResult = sumVal;
    else if (strb.selSub)   rawResult = diffVal;
    else if (strb.selShift) rawResult = shiftVal;
  end
endmodule

// File: rtl/exu_top.sv
module exu_top
  import exu_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int SHAMT_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [OP_W-1:0]    opSel,
  input  logic [DATA_W-1:0]  opA,
  input  logic [DATA_W-1:0]  opB,
  input  logic [SHAMT_W-1:0] shAmt,
  input  logic               wideEn,
  output logic [DATA_W-1:0]  result,
  output logic               wrEn,
  output logic               ovfExc,
  output logic               rsvdExc
);
  exuStrobe_t strb;
  logic [DATA_W-1:0] rawResult;
  logic sumOvf;

  exu_ctrl u_ctrl (
    .opSel (opSel),
    .strb  (strb)
  );

  exu_datapath #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_dp (
    .strb      (strb),
    .opA       (opA),
    .opB       (opB),
    .shAmt     (shAmt),
    .rawResult (rawResult),
    .sumOvf    (sumOvf)
  );

  logic rsvdNow;
  logic ovfNow;
  logic wrNow;
  assign rsvdNow = !strb.legal || (strb.needWide && !wideEn);
  assign ovfNow  = strb.trapOvf && sumOvf && !rsvdNow;
  assign wrNow   = !rsvdNow && !ovfNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result  <= '0;
      wrEn    <= 1'b0;
      ovfExc  <= 1'b0;
      rsvdExc <= 1'b0;
    end else begin
      result  <= wrNow ? rawResult : '0;
      wrEn    <= wrNow;
      ovfExc  <= ovfNow;
      rsvdExc <= rsvdNow;
    end
  end

  // R13: an exception blocks the write and zeroes the result
  assert_wr_excl_R13: assert property (@(posedge clk) disable iff (!rstN)
    (ovfExc || rsvdExc) |-> (!wrEn && result == '0));
  assert_one_exc_R13: assert property (@(posedge clk) disable iff (!rstN)
    !(ovfExc && rsvdExc));
  // R4/R5/R6: overflow only from checked add or subtract
  assert_ovf_source_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(!rstN) && ovfExc) |-> ($past(opSel) == OP_ADDT || $past(opSel) == OP_SUBT));
  // R7: doubleword code with mode off is refused
  assert_rsvd_mode_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(wideEn) && $past(opSel) >= 4'd2 && $past(opSel) <= 4'd11) |-> rsvdExc);
  // R12: unused codes are refused
  assert_undef_R12: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(opSel) >= 4'd12) |-> (rsvdExc && !wrEn));
  // R2/R3: comparisons produce a single bit
  assert_slt_bit_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(opSel) <= 4'd1) |-> (wrEn && result[DATA_W-1:1] == '0));
endmodule

// File: tb/exu_top_bench.sv
module exu_top_bench;
  typedef struct {
    logic [3:0]  op;
    logic [63:0] res;
    logic        wr;
    logic        ovf;
    logic        rsvd;
    string       tag;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  opSel = '0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic [4:0]  shAmt = '0;
  logic        wideEn = 1'b0;
  logic [63:0] result;
  logic        wrEn, ovfExc, rsvdExc;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  expItem_t q[$];

  always #4 clk = ~clk;  // 125 MHz

  exu_top u_exu_top (
    .clk(clk), .rstN(rstN), .opSel(opSel), .opA(opA), .opB(opB),
    .shAmt(shAmt), .wideEn(wideEn), .result(result), .wrEn(wrEn),
    .ovfExc(ovfExc), .rsvdExc(rsvdExc)
  );

  function automatic expItem_t model(logic [3:0] op, logic [63:0] a, logic [63:0] b,
                                     logic [4:0] sh, logic m);
    expItem_t e;
    longint sa, sb;
    logic [63:0] d;
    int amt;
    sa = a; sb = b;
    e.op = op; e.res = '0; e.wr = 1'b1; e.ovf = 1'b0; e.rsvd = 1'b0; e.tag = "R12";
    amt = int'(sh) + ((op >= 4'd9) ? 32 : 0);
    if (op >= 4'd12) begin e.rsvd = 1; e.wr = 0; return e; end
    if (op >= 4'd2 && !m) begin e.rsvd = 1; e.wr = 0; e.tag = "R7"; return e; end
    case (op)
      4'd0: begin e.res = (sa < sb) ? 64'd1 : 64'd0; e.tag = "R2"; end
      4'd1: begin e.res = (a < b) ? 64'd1 : 64'd0; e.tag = "R3"; end
      4'd2, 4'd3: begin
        d = a + b;
        e.tag = (op == 4'd2) ? "R4" : "R6";
        if (op == 4'd2 && (a[63] == b[63]) && (d[63] != a[63])) begin e.ovf = 1; e.wr = 0; end
        else e.res = d;
      end
      4'd4, 4'd5: begin
        d = a - b;
        e.tag = (op == 4'd4) ? "R5" : "R6";
        if (op == 4'd4 && (a[63] != b[63]) && (d[63] != a[63])) begin e.ovf = 1; e.wr = 0; end
        else e.res = d;
      end
      4'd6, 4'd9:  begin e.res = b << amt; e.tag = (op == 4'd6) ? "R8" : "R11"; end
      4'd7, 4'd10: begin e.res = b >> amt; e.tag = (op == 4'd7) ? "R9" : "R11"; end
      default:     begin e.res = sb >>> amt; e.tag = (op == 4'd8) ? "R10" : "R11"; end
    endcase
    return e;
  endfunction

  task automatic drive(logic [3:0] op, logic [63:0] a, logic [63:0] b, logic [4:0] sh, logic m);
    @(negedge clk);
    opSel = op; opA = a; opB = b; shAmt = sh; wideEn = m;
    q.push_back(model(op, a, b, sh, m));
  endtask

  // monitor: one-cycle latency (R13)
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        expItem_t e;
        e = q.pop_front();
        checks++;
        if (wrEn !== e.wr || ovfExc !== e.ovf || rsvdExc !== e.rsvd || result !== e.res) begin
          fails++;
          $display("FAIL %s/R13 op=%0d: got res=%h wr=%b ovf=%b rsvd=%b, exp res=%h wr=%b ovf=%b rsvd=%b",
                   e.tag, e.op, result, wrEn, ovfExc, rsvdExc, e.res, e.wr, e.ovf, e.rsvd);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  localparam logic [63:0] MAXP = 64'h7fff_ffff_ffff_ffff;
  localparam logic [63:0] MINN = 64'h8000_0000_0000_0000;
  localparam logic [63:0] ONES = 64'hffff_ffff_ffff_ffff;

  initial begin
    logic [63:0] seed;
    seed = 64'h1234_5678_9abc_def1;
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (result !== '0 || wrEn !== 0 || ovfExc !== 0 || rsvdExc !== 0) begin
      fails++;
      $display("FAIL R1 reset: got res=%h wr=%b ovf=%b rsvd=%b, exp all zero",
               result, wrEn, ovfExc, rsvdExc);
    end
    rstN = 1'b1;
    // R2 / R3 comparisons, mode on and off
    drive(4'd0, ONES, 64'd1, 0, 1);
    drive(4'd1, ONES, 64'd1, 0, 1);
    drive(4'd0, 64'd5, 64'd5, 0, 0);
    drive(4'd1, 64'd1, ONES, 0, 0);
    drive(4'd0, MINN, MAXP, 0, 1);
    // R4 checked add
    drive(4'd2, MAXP, 64'd1, 0, 1);
    drive(4'd2, MINN, ONES, 0, 1);
    drive(4'd2, MAXP, ONES, 0, 1);
    // R6 wrapping add/sub
    drive(4'd3, MAXP, 64'd1, 0, 1);
    drive(4'd5, MINN, 64'd1, 0, 1);
    // R5 checked subtract
    drive(4'd4, MINN, 64'd1, 0, 1);
    drive(4'd4, 64'd0, MINN, 0, 1);
    drive(4'd4, ONES, MINN, 0, 1);
    drive(4'd4, 64'd10, 64'd3, 0, 1);
    // R8-R11 shifts incl. boundaries
    drive(4'd6, ONES, ONES, 0, 1);
    drive(4'd6, 64'h0123_4567_89ab_cdef, 64'h0123_4567_89ab_cdef, 31, 1);
    drive(4'd7, 0, MINN, 31, 1);
    drive(4'd8, 0, MINN, 31, 1);
    drive(4'd8, 0, MAXP, 5, 1);
    drive(4'd9, 0, 64'd1, 31, 1);
    drive(4'd10, 0, ONES, 31, 1);
    drive(4'd11, 0, MINN, 31, 1);
    drive(4'd11, 0, 64'h4000_0000_0000_0000, 0, 1);
    // R7 mode gate on doubleword ops
    drive(4'd3, 64'd1, 64'd2, 0, 0);
    drive(4'd2, MAXP, 64'd1, 0, 0);
    drive(4'd11, 0, MINN, 3, 0);
    // R12 unused codes
    for (int c = 12; c < 16; c++) drive(4'(c), 64'd1, 64'd2, 0, 1);
    // mixed stream
    for (int n = 0; n < 600; n++) begin
      logic [63:0] a, b;
      seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
      a = seed;
      if (seed[5:4] == 2'b00) a = {seed[63], 63'(0)} | (seed[62] ? MAXP : 64'd0);
      seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
      b = seed;
      if (seed[9:8] == 2'b01) b = seed[7] ? MINN : ONES;
      drive(seed[63:60], a, b, seed[50:46], seed[40:37] != 4'd0);
    end
    @(negedge clk);
    while (q.size() > 0) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule